// File: doc/BRIEF.md
# Binary Calendar Clock with Tick Divider

This block keeps the wall time and the calendar date in seven separate binary fields: second, minute, hour, day of month, month, year (as an offset from 2000) and weekday. A two-stage divider turns the system clock into a slow tick. A down-counter of those ticks marks each completed second, and on that second every field that needs to roll moves forward. Month lengths and the February leap-year rule are taken into account.

A radio time decoder can overwrite all seven fields in a single cycle when it holds a complete time set that it has already checked. That load also restarts the count toward the next second. Each advance or load raises a seven-bit change vector for one cycle. A display controller uses it to redraw only the digits that changed.

Top module: `cal_clock_top`

## Requirements
- R1: While `rst_n` is low the outputs read 00:00:00, day 1, month 1, year 0, weekday 5, and `chg_flags` is zero.
- R2: The clock divides by `PRESCALE` and then by `CMP_DIV` to make a tick. Counted from reset release, the tick appears first at rising edge `PRESCALE*CMP_DIV`, and one tick later than that edge and every `PRESCALE*CMP_DIV` edges after it. Every `TICKS_PER_SEC`-th tick advances the time by one second, and the fields change on the rising edge that follows that tick.
- R3: Seconds and minutes wrap from 59 to 0, and each wrap carries into the next field. Hours wrap from 23 to 0 and carry into the day.
- R4: A day advances to 1 of the next month after day 30 of months 4, 6, 9 and 11, and after day 31 of months 1, 3, 5, 7, 8, 10 and 12.
- R5: February ends after day 29 when the year offset is divisible by 4. It ends after day 28 otherwise.
- R6: Month 12 wraps to 1 and increments the year. Year 99 wraps to 0.
- R7: The weekday (0 to 6) increments whenever the day changes through an advance, and it wraps from 6 to 0.
- R8: When `load_valid` is high at a rising edge, all seven fields take the load inputs at that edge and the second count restarts at `TICKS_PER_SEC`. This happens even if a second would have completed at the same edge.
- R9: `chg_flags` is high for exactly the one cycle after an advance or load. Bit 0 is seconds, then minutes, hours, day, month, year, and bit 6 is weekday. An advance sets only the bits of the fields that changed. A load sets all seven bits. In every other cycle the vector is zero.
- R10: No field changes in a cycle without an advance or a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_valid | input | 1 | Overwrite all fields with the load inputs |
| load_sec | input | 6 | Seconds to load, 0 to 59 |
| load_min | input | 6 | Minutes to load, 0 to 59 |
| load_hour | input | 5 | Hours to load, 0 to 23 |
| load_day | input | 5 | Day of month to load, 1 to month length |
| load_month | input | 4 | Month to load, 1 to 12 |
| load_year | input | 7 | Year offset from 2000 to load, 0 to 99 |
| load_wday | input | 3 | Weekday to load, 0 to 6 |
| sec | output | 6 | Current seconds |
| min | output | 6 | Current minutes |
| hour | output | 5 | Current hours |
| day | output | 5 | Current day of month |
| month | output | 4 | Current month |
| year | output | 7 | Current year offset |
| wday | output | 3 | Current weekday |
| chg_flags | output | 7 | One-cycle per-field change vector |

## Verification
A divider or second counter that is off by one shifts the edge at which `sec` moves. The bench compares every output against its own cycle model on every cycle, so that shift shows up within one second of ticks. A wrong month-length or leap decision shows up at the day, month or weekday outputs on the first rollover after a load of the last day of that month. A stale or missing change flag shows up in the very cycle after the advance, and a lost load priority shows up at the edge of the load itself.

// File: rtl/cal_pkg.sv
// Shared types and helpers for the calendar clock.
// Assumes fields are kept in plain binary, year as offset from 2000.
package cal_pkg;

    typedef struct packed {
        logic [2:0] wday;
        logic [6:0] year;
        logic [3:0] month;
        logic [4:0] day;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } cal_t;

    localparam int NFIELD = 7;
    localparam int F_SEC   = 0;
    localparam int F_MIN   = 1;
    localparam int F_HOUR  = 2;
    localparam int F_DAY   = 3;
    localparam int F_MONTH = 4;
    localparam int F_YEAR  = 5;
    localparam int F_WDAY  = 6;

    localparam cal_t CAL_RESET = '{wday: 3'd5, year: 7'd0, month: 4'd1,
                                   day: 5'd1, hour: 5'd0, min: 6'd0, sec: 6'd0};

    // Last valid day of a month; leap when year offset is a multiple of 4.
    function automatic logic [4:0] month_len(input logic [3:0] m, input logic [6:0] y);
        logic [4:0] len;
        case (m)
            4'd2:                      len = (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   len = 5'd30;
            default:                   len = 5'd31;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/tick_divider.sv
// Two-stage clock divider: a prescaler of PRESCALE cycles feeds a
// compare divider of CMP_DIV strobes. Emits a registered one-cycle tick.
// Assumes PRESCALE >= 2 and CMP_DIV >= 2.
module tick_divider #(
    parameter int PRESCALE = 256,
    parameter int CMP_DIV  = 80
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = $clog2(PRESCALE);
    localparam int CW = $clog2(CMP_DIV);
    localparam logic [PW-1:0] P_LAST = PW'(PRESCALE - 1);
    localparam logic [CW-1:0] C_LAST = CW'(CMP_DIV - 1);

    logic [PW-1:0] pre_q;
    logic [CW-1:0] cmp_q;
    logic          strobe;

    assign strobe = (pre_q == P_LAST);

    // Prescaler stage: free-running count of system clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)      pre_q <= '0;
        else if (strobe) pre_q <= '0;
        else             pre_q <= pre_q + 1'b1;
    end

    // Compare stage: counts prescaler strobes and clears on match.
    always_ff @(posedge clk) begin
        if (!rst_n)              cmp_q <= '0;
        else if (strobe)         cmp_q <= (cmp_q == C_LAST) ? '0 : cmp_q + 1'b1;
    end

    // Tick register: one pulse per completed compare period.
    always_ff @(posedge clk) begin
        if (!rst_n) tick <= 1'b0;
        else        tick <= strobe && (cmp_q == C_LAST);
    end
endmodule

// File: rtl/sec_counter.sv
// Counts ticks down from TICKS_PER_SEC; flags the tick that completes a
// second. A reload request restarts the count and wins over a tick.
module sec_counter #(
    parameter int TICKS_PER_SEC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic reload,
    output logic sec_pulse
);
    localparam int TW = $clog2(TICKS_PER_SEC + 1);
    localparam logic [TW-1:0] TOP = TW'(TICKS_PER_SEC);
    localparam logic [TW-1:0] ONE = TW'(1);

    logic [TW-1:0] cnt_q;

    assign sec_pulse = tick && (cnt_q == ONE);

    // Down-count of ticks with reload at the end of each second.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= TOP;
        else if (reload) cnt_q <= TOP;
        else if (tick)   cnt_q <= (cnt_q == ONE) ? TOP : cnt_q - 1'b1;
    end
endmodule

// File: rtl/cal_advance.sv
// Combinational one-second step of the calendar with per-field change
// vector. Assumes the input is a valid time and date.
module cal_advance
    import cal_pkg::*;
(
    input  cal_t              cur,
    output cal_t              nxt,
    output logic [NFIELD-1:0] diff
);
    logic [NFIELD-1:0][6:0] cur_f, nxt_f;

    // Ripple-carry step through seconds, minutes, hours, day, month, year.
    always_comb begin
        nxt = cur;
        if (cur.sec != 6'd59) begin
            nxt.sec = cur.sec + 6'd1;
        end else begin
            nxt.sec = 6'd0;
            if (cur.min != 6'd59) begin
                nxt.min = cur.min + 6'd1;
            end else begin
                nxt.min = 6'd0;
                if (cur.hour != 5'd23) begin
                    nxt.hour = cur.hour + 5'd1;
                end else begin
                    nxt.hour = 5'd0;
                    nxt.wday = (cur.wday == 3'd6) ? 3'd0 : cur.wday + 3'd1;
                    if (cur.day != month_len(cur.month, cur.year)) begin
                        nxt.day = cur.day + 5'd1;
                    end else begin
                        nxt.day = 5'd1;
                        if (cur.month != 4'd12) begin
                            nxt.month = cur.month + 4'd1;
                        end else begin
                            nxt.month = 4'd1;
                            nxt.year  = (cur.year == 7'd99) ? 7'd0 : cur.year + 7'd1;
                        end
                    end
                end
            end
        end
    end

    // Widen every field to a common width for the per-field compare.
    always_comb begin
        cur_f[F_SEC]   = {1'b0, cur.sec};   nxt_f[F_SEC]   = {1'b0, nxt.sec};
        cur_f[F_MIN]   = {1'b0, cur.min};   nxt_f[F_MIN]   = {1'b0, nxt.min};
        cur_f[F_HOUR]  = {2'b0, cur.hour};  nxt_f[F_HOUR]  = {2'b0, nxt.hour};
        cur_f[F_DAY]   = {2'b0, cur.day};   nxt_f[F_DAY]   = {2'b0, nxt.day};
        cur_f[F_MONTH] = {3'b0, cur.month}; nxt_f[F_MONTH] = {3'b0, nxt.month};
        cur_f[F_YEAR]  = cur.year;          nxt_f[F_YEAR]  = nxt.year;
        cur_f[F_WDAY]  = {4'b0, cur.wday};  nxt_f[F_WDAY]  = {4'b0, nxt.wday};
    end

    for (genvar i = 0; i < NFIELD; i++) begin : g_diff
        assign diff[i] = (cur_f[i] != nxt_f[i]);
    end
endmodule

// File: rtl/cal_clock_top.sv
// Calendar clock top: divider, second counter, one-second step and the
// field registers. A load overwrites all fields and has priority.
module cal_clock_top
    import cal_pkg::*;
#(
    parameter int PRESCALE      = 256,
    parameter int CMP_DIV       = 80,
    parameter int TICKS_PER_SEC = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_valid,
    input  logic [5:0] load_sec,
    input  logic [5:0] load_min,
    input  logic [4:0] load_hour,
    input  logic [4:0] load_day,
    input  logic [3:0] load_month,
    input  logic [6:0] load_year,
    input  logic [2:0] load_wday,
    output logic [5:0] sec,
    output logic [5:0] min,
    output logic [4:0] hour,
    output logic [4:0] day,
    output logic [3:0] month,
    output logic [6:0] year,
    output logic [2:0] wday,
    output logic [6:0] chg_flags
);
    logic              tick;
    logic              sec_pulse;
    cal_t              cal_q, cal_nxt, cal_ld;
    logic [NFIELD-1:0] diff, flags_q;

    tick_divider #(.PRESCALE(PRESCALE), .CMP_DIV(CMP_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    sec_counter #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_sec (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reload(load_valid),
        .sec_pulse(sec_pulse)
    );

    cal_advance u_adv (.cur(cal_q), .nxt(cal_nxt), .diff(diff));

    assign cal_ld = '{wday: load_wday, year: load_year, month: load_month,
                      day: load_day, hour: load_hour, min: load_min, sec: load_sec};

    // Field registers and change vector: load first, then advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_q   <= CAL_RESET;
            flags_q <= '0;
        end else if (load_valid) begin
            cal_q   <= cal_ld;
            flags_q <= '1;
        end else if (sec_pulse) begin
            cal_q   <= cal_nxt;
            flags_q <= diff;
        end else begin
            flags_q <= '0;
        end
    end

    assign sec       = cal_q.sec;
    assign min       = cal_q.min;
    assign hour      = cal_q.hour;
    assign day       = cal_q.day;
    assign month     = cal_q.month;
    assign year      = cal_q.year;
    assign wday      = cal_q.wday;
    assign chg_flags = flags_q;
endmodule

// File: rtl/cal_clock_chk.sv
// Property checker for cal_clock_top, attached by bind below.
module cal_clock_chk
    import cal_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       load_valid,
    input logic       adv_pulse,
    input logic [5:0] sec,
    input logic [5:0] min,
    input logic [4:0] hour,
    input logic [4:0] day,
    input logic [3:0] month,
    input logic [6:0] year,
    input logic [2:0] wday,
    input logic [6:0] chg_flags
);
    // R3
    time_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec <= 6'd59) && (min <= 6'd59) && (hour <= 5'd23));

    // R4
    day_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (day >= 5'd1) && (day <= month_len(month, year)) && (wday <= 3'd6));

    // R9
    idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_valid && !adv_pulse) |=> (chg_flags == 7'd0));

    // R8
    load_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |=> (chg_flags == 7'h7f));

    // R10
    hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_valid && !adv_pulse) |=> ($stable(sec) && $stable(min) && $stable(hour)
            && $stable(day) && $stable(month) && $stable(year) && $stable(wday)));

    // R7
    wday_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_pulse && !load_valid) |=> (chg_flags[3] == chg_flags[6]));

    // R3
    sec_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_pulse && !load_valid) |=> chg_flags[0]);
endmodule

bind cal_clock_top cal_clock_chk u_chk (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .adv_pulse(sec_pulse),
    .sec(sec), .min(min), .hour(hour), .day(day), .month(month),
    .year(year), .wday(wday), .chg_flags(chg_flags)
);

// File: tb/tb_cal_clock_top.sv
// Bench: cycle model of the requirements, directed corners and random loads.
module tb_cal_clock_top;
    localparam int P = 2;
    localparam int C = 3;
    localparam int T = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld = 1'b0;
    logic [5:0] l_sec = '0, l_min = '0;
    logic [4:0] l_hour = '0, l_day = 5'd1;
    logic [3:0] l_month = 4'd1;
    logic [6:0] l_year = '0;
    logic [2:0] l_wday = '0;
    logic [5:0] sec, min;
    logic [4:0] hour, day;
    logic [3:0] month;
    logic [6:0] year;
    logic [2:0] wday;
    logic [6:0] chg_flags;

    int tests = 0, fails = 0;
    int mp, mc, mcnt;
    bit mtick;
    int ms, mmin, mh, md, mmo, my, mw;
    logic [6:0] mf;

    always #5 clk = ~clk;

    cal_clock_top #(.PRESCALE(P), .CMP_DIV(C), .TICKS_PER_SEC(T)) dut (
        .clk(clk), .rst_n(rst_n), .load_valid(ld),
        .load_sec(l_sec), .load_min(l_min), .load_hour(l_hour), .load_day(l_day),
        .load_month(l_month), .load_year(l_year), .load_wday(l_wday),
        .sec(sec), .min(min), .hour(hour), .day(day), .month(month),
        .year(year), .wday(wday), .chg_flags(chg_flags)
    );

    function automatic int dim(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic model_second();
        int o[7];
        o = '{ms, mmin, mh, md, mmo, my, mw};
        ms++;
        if (ms == 60) begin
            ms = 0; mmin++;
            if (mmin == 60) begin
                mmin = 0; mh++;
                if (mh == 24) begin
                    mh = 0; mw = (mw + 1) % 7; md++;
                    if (md > dim(mmo, my)) begin
                        md = 1; mmo++;
                        if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
                    end
                end
            end
        end
        mf = {7'(o[6] != mw), 7'(o[5] != my) , 7'(o[4] != mmo), 7'(o[3] != md),
              7'(o[2] != mh), 7'(o[1] != mmin), 7'(o[0] != ms)} != 0 ? 7'd0 : 7'd0;
        mf[0] = (o[0] != ms); mf[1] = (o[1] != mmin); mf[2] = (o[2] != mh);
        mf[3] = (o[3] != md); mf[4] = (o[4] != mmo); mf[5] = (o[5] != my);
        mf[6] = (o[6] != mw);
    endtask

    task automatic compare(input string tag);
        logic [35:0] act, exp;
        act = {wday, year, month, day, hour, min, sec};
        exp = {3'(mw), 7'(my), 4'(mmo), 5'(md), 5'(mh), 6'(mmin), 6'(ms)};
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s fields act=%h exp=%h", tag, act, exp);
        end
        tests++;
        if (chg_flags !== mf) begin
            fails++;
            $display("FAIL %s R9 flags act=%b exp=%b", tag, chg_flags, mf);
        end
    endtask

    // One clock: update the model from the inputs, then check after the edge.
    task automatic step(input string tag);
        bit adv, nt;
        adv = mtick && (mcnt == 1);
        if (ld) begin
            ms = l_sec; mmin = l_min; mh = l_hour; md = l_day;
            mmo = l_month; my = l_year; mw = l_wday;
            mcnt = T; mf = 7'h7f;
        end else if (adv) begin
            model_second(); mcnt = T;
        end else begin
            mf = 7'd0;
            if (mtick) mcnt--;
        end
        nt = (mp == P - 1) && (mc == C - 1);
        if (mp == P - 1) begin mp = 0; mc = (mc == C - 1) ? 0 : mc + 1; end
        else mp++;
        mtick = nt;
        @(posedge clk); #1;
        compare(tag);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic do_load(input int s, input int mi, input int h, input int d,
                           input int mo, input int y, input int w, input string tag);
        l_sec = 6'(s); l_min = 6'(mi); l_hour = 5'(h); l_day = 5'(d);
        l_month = 4'(mo); l_year = 7'(y); l_wday = 3'(w);
        ld = 1'b1;
        step(tag);
        ld = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int seed, mo, y;
        seed = $urandom(32'h5a17);
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        tests++;
        if ({sec, min, hour, day, month, year, wday, chg_flags} !==
            {6'd0, 6'd0, 5'd0, 5'd1, 4'd1, 7'd0, 3'd5, 7'd0}) begin
            fails++;
            $display("FAIL R1 reset act=%h exp=%h",
                     {sec, min, hour, day, month, year, wday, chg_flags},
                     {6'd0, 6'd0, 5'd0, 5'd1, 4'd1, 7'd0, 3'd5, 7'd0});
        end
        mp = 0; mc = 0; mtick = 0; mcnt = T;
        ms = 0; mmin = 0; mh = 0; md = 1; mmo = 1; my = 0; mw = 5; mf = 0;
        rst_n = 1'b1;

        run(3 * P * C * T + 5, "R2");

        do_load(58, 59, 23, 31, 12, 99, 6, "R8");
        run(60, "R6/R7");
        do_load(59, 59, 23, 28, 2, 4, 1, "R5");   run(30, "R5");
        do_load(59, 59, 23, 28, 2, 5, 1, "R5");   run(30, "R5");
        do_load(59, 59, 23, 29, 2, 8, 3, "R5");   run(30, "R5");
        do_load(59, 59, 23, 28, 2, 0, 2, "R5");   run(30, "R5");
        do_load(59, 59, 23, 30, 4, 10, 0, "R4");  run(30, "R4");
        do_load(59, 59, 23, 31, 1, 10, 4, "R4");  run(30, "R4");
        do_load(59, 59, 23, 30, 11, 10, 4, "R4"); run(30, "R4");
        do_load(59, 59, 23, 30, 8, 10, 4, "R4");  run(30, "R4");
        do_load(59, 0, 0, 15, 6, 20, 2, "R3");    run(30, "R3");
        do_load(59, 59, 0, 15, 6, 20, 2, "R3");   run(30, "R3");

        // R8: load on the very edge a second would complete
        for (int k = 0; k < 3; k++) begin
            while (!(mtick && mcnt == 1)) step("R10");
            do_load(10 + k, 20, 5, 3, 3, 21, 1, "R8");
            run(P * C * T + 3, "R8");
        end

        // R9/R10: random valid loads mixed with free running
        for (int i = 0; i < 300; i++) begin
            mo = 1 + $urandom_range(11);
            y = $urandom_range(99);
            if ($urandom_range(3) == 0)
                do_load(59, 59, 23, dim(mo, y), mo, y, $urandom_range(6), "R9");
            else
                do_load($urandom_range(59), $urandom_range(59), $urandom_range(23),
                        1 + $urandom_range(dim(mo, y) - 1), mo, y, $urandom_range(6), "R9");
            run($urandom_range(40), "R10");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule